// File: doc/BRIEF.md
# Prefetch Outcome Classifier

This block is a performance monitor that sits beside the private first-level data cache of one core in a multicore chip. It keeps a small record for each line that the prefetcher has brought into that cache. The record tells what the prefetch has turned out to be so far. Four event strobes move each record through eight outcome categories:

- a local hit on the line,
- a local miss on a line that the prefetch pushed out,
- a remote invalidation that the prefetch set off,
- a remote read served from this cache.

When the line leaves the cache, the block adds one to the saturating counter of the category the line ended in.

Logic outside this block turns raw cache and coherence traffic into the strobes and slot indices. The counters can be read at any time through a combinational read port: a category code goes in and the count comes out. A synchronous clear empties every slot and zeroes every counter, so a new measurement window can start.

Top module: `pfx_outcome_tracker`

## Requirements
- R1: A fill strobe makes its slot valid, with category Useless (code 0). Category codes are: 0 Useless, 1 Useful, 2 Harmful, 3 Useless/Remote, 4 Useless/Conflict, 5 Useful/Conflict, 6 Harmful/Conflict, 7 Useless/Conflict/Remote.
- R2: Event kind 0 (local hit on the prefetched line) moves code 0 to 1 and code 4 to 5.
- R3: Event kind 1 (local miss on a displaced line) moves code 0 to 4, 1 to 5, 2 to 6 and 3 to 7.
- R4: Event kind 2 (remote invalidation set off by the prefetch) moves code 0 to 2 and code 4 to 6.
- R5: Event kind 3 (remote read served cache-to-cache) moves code 0 to 3 and code 4 to 7.
- R6: An event with no transition defined from the current category leaves the category unchanged.
- R7: An eviction of a valid slot adds exactly one to the counter of that slot's category and invalidates the slot. An eviction of an invalid slot counts nothing.
- R8: An event aimed at an invalid slot is ignored. The slot stays invalid, and a later fill still starts at Useless.
- R9: When an event and an eviction hit the same slot in one cycle, the event is applied first and the resulting category is counted.
- R10: A fill into a slot that is still valid first counts the slot's current category, as an eviction would, and then restarts the slot at Useless.
- R11: Each counter is CNT_W bits wide, stays at its all-ones maximum once it gets there, and never decreases except on clear.
- R12: A synchronous clear zeroes all counters and invalidates all slots on the next clock edge.
- R13: After reset all counters read zero and all slots are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of slots and counters |
| fill_vld | input | 1 | Prefetch fill has completed |
| fill_slot | input | SLOT_W | Slot being filled |
| evt_vld | input | 1 | Classification event strobe |
| evt_kind | input | 2 | Event kind, 0 to 3 as in R2 to R5 |
| evt_slot | input | SLOT_W | Slot the event refers to |
| evict_vld | input | 1 | Tracked line evicted |
| evict_slot | input | SLOT_W | Slot being evicted |
| rd_cat | input | 3 | Category code to read |
| rd_count | output | CNT_W | Counter value of category rd_cat |

## Verification
Every sequence of one, two and three events that starts from a fresh fill is driven, and the eviction at the end of each sequence is checked. Comparing all eight counters after each sequence separates a wrong transition from a missing one, or one that should have been ignored. Same-cycle patterns are applied next: event with eviction, event to an empty slot, and refill of a live slot. They show whether the block keeps event-then-evict-then-fill order or drops or double-counts a line. A long run of fill and eviction pairs on a narrow counter checks saturation, and a clear issued mid-stream checks that stale slots are forgotten.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    // Outcome category codes (R1)
    typedef enum logic [2:0] {
        CAT_USELESS       = 3'd0,
        CAT_USEFUL        = 3'd1,
        CAT_HARMFUL       = 3'd2,
        CAT_USELESS_RMT   = 3'd3,
        CAT_USELESS_CNF   = 3'd4,
        CAT_USEFUL_CNF    = 3'd5,
        CAT_HARMFUL_CNF   = 3'd6,
        CAT_USELESS_CNF_R = 3'd7
    } pfx_cat_e;

    // Event kinds (R2..R5)
    typedef enum logic [1:0] {
        EV_LOCAL_HIT   = 2'd0,
        EV_DISPLACED   = 2'd1,
        EV_REMOTE_INV  = 2'd2,
        EV_REMOTE_READ = 2'd3
    } pfx_evt_e;

    localparam int NUM_CAT = 8;

endpackage

// File: rtl/pfx_transition.sv
module pfx_transition
    import pfx_pkg::*;
(
    input  logic [2:0] cat_in,
    input  logic [1:0] kind,
    output logic [2:0] cat_out
);
    pfx_cat_e cur;
    pfx_cat_e nxt;

    always_comb begin
        cur = pfx_cat_e'(cat_in);
        nxt = cur;                       // R6: undefined moves keep state
        unique case (pfx_evt_e'(kind))
            EV_LOCAL_HIT: begin          // R2
                if (cur == CAT_USELESS)          nxt = CAT_USEFUL;
                else if (cur == CAT_USELESS_CNF) nxt = CAT_USEFUL_CNF;
            end
            EV_DISPLACED: begin          // R3
                unique case (cur)
                    CAT_USELESS:     nxt = CAT_USELESS_CNF;
                    CAT_USEFUL:      nxt = CAT_USEFUL_CNF;
                    CAT_HARMFUL:     nxt = CAT_HARMFUL_CNF;
                    CAT_USELESS_RMT: nxt = CAT_USELESS_CNF_R;
                    default:         nxt = cur;
                endcase
            end
            EV_REMOTE_INV: begin         // R4
                if (cur == CAT_USELESS)          nxt = CAT_HARMFUL;
                else if (cur == CAT_USELESS_CNF) nxt = CAT_HARMFUL_CNF;
            end
            EV_REMOTE_READ: begin        // R5
                if (cur == CAT_USELESS)          nxt = CAT_USELESS_RMT;
                else if (cur == CAT_USELESS_CNF) nxt = CAT_USELESS_CNF_R;
            end
            default: nxt = cur;
        endcase
        cat_out = nxt;
    end

endmodule

// File: rtl/pfx_cat_counter.sv
module pfx_cat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};
        if (clr)              cnt_d = '0;           // R12
        else if (sum[CNT_W])  cnt_d = MAXV;         // R11 saturate
        else                  cnt_d = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;                    // R13
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/pfx_outcome_tracker.sv
module pfx_outcome_tracker
    import pfx_pkg::*;
#(
    parameter  int SLOTS  = 16,
    parameter  int CNT_W  = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fill_vld,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic              evt_vld,
    input  logic [1:0]        evt_kind,
    input  logic [SLOT_W-1:0] evt_slot,
    input  logic              evict_vld,
    input  logic [SLOT_W-1:0] evict_slot,
    input  logic [2:0]        rd_cat,
    output logic [CNT_W-1:0]  rd_count
);

    typedef struct packed {
        logic [SLOTS-1:0]      valid;
        logic [SLOTS-1:0][2:0] cat;
    } slot_t;

    slot_t slot_d, slot_q;

    logic [2:0] evt_cur, evt_nxt;
    logic [1:0] inc_d [NUM_CAT];
    logic [CNT_W-1:0] cnt [NUM_CAT];

    // Output of the single event transition
    assign evt_cur = slot_q.cat[evt_slot];

    pfx_transition u_trans (
        .cat_in  (evt_cur),
        .kind    (evt_kind),
        .cat_out (evt_nxt)
    );

    // Next state: event, then eviction, then fill (R9, R10)
    always_comb begin
        slot_d = slot_q;
        for (int c = 0; c < NUM_CAT; c++) inc_d[c] = 2'd0;

        // R2..R5, R8: event only on a valid slot
        if (evt_vld && slot_q.valid[evt_slot])
            slot_d.cat[evt_slot] = evt_nxt;

        // R7: count final category of a valid evicted slot
        if (evict_vld && slot_d.valid[evict_slot]) begin
            inc_d[slot_d.cat[evict_slot]] = inc_d[slot_d.cat[evict_slot]] + 2'd1;
            slot_d.valid[evict_slot] = 1'b0;
        end

        // R1, R10: fill restarts slot, counting any live occupant
        if (fill_vld) begin
            if (slot_d.valid[fill_slot])
                inc_d[slot_d.cat[fill_slot]] = inc_d[slot_d.cat[fill_slot]] + 2'd1;
            slot_d.valid[fill_slot] = 1'b1;
            slot_d.cat[fill_slot]   = CAT_USELESS;
        end

        // R12
        if (clr) begin
            slot_d = '0;
            for (int c = 0; c < NUM_CAT; c++) inc_d[c] = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;                   // R13
        else        slot_q <= slot_d;
    end

    // One saturating counter per outcome category (R11)
    for (genvar c = 0; c < NUM_CAT; c++) begin : g_cnt
        pfx_cat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc_d[c]),
            .count (cnt[c])
        );
    end

    assign rd_count = cnt[rd_cat];

    // Flattened views for the bound checker
    logic [SLOTS-1:0]         valid_flat;
    logic [SLOTS*3-1:0]       cat_flat;
    logic [NUM_CAT*CNT_W-1:0] cnt_flat;

    assign valid_flat = slot_q.valid;
    for (genvar s = 0; s < SLOTS; s++) begin : g_flat_s
        assign cat_flat[s*3 +: 3] = slot_q.cat[s];
    end
    for (genvar c = 0; c < NUM_CAT; c++) begin : g_flat_c
        assign cnt_flat[c*CNT_W +: CNT_W] = cnt[c];
    end

endmodule

// File: rtl/pfx_outcome_tracker_chk.sv
module pfx_outcome_tracker_chk #(
    parameter  int SLOTS  = 16,
    parameter  int CNT_W  = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic                fill_vld,
    input logic [SLOT_W-1:0]   fill_slot,
    input logic                evt_vld,
    input logic [SLOT_W-1:0]   evt_slot,
    input logic                evict_vld,
    input logic [SLOT_W-1:0]   evict_slot,
    input logic [SLOTS-1:0]    valid_flat,
    input logic [SLOTS*3-1:0]  cat_flat,
    input logic [8*CNT_W-1:0]  cnt_flat
);
    logic [CNT_W+3:0] total;

    always_comb begin
        total = '0;
        for (int c = 0; c < 8; c++)
            total = total + {4'd0, cnt_flat[c*CNT_W +: CNT_W]};
    end

    p_fill_useless_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld && !clr |=> valid_flat[$past(fill_slot)] &&
                             cat_flat[$past(fill_slot)*3 +: 3] == 3'd0);

    p_evict_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld && !(fill_vld && fill_slot == evict_slot) |=>
            !valid_flat[$past(evict_slot)]);

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> total <= $past(total) + 2);

    p_no_decrease_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> total >= $past(total));

    p_ignore_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vld && !valid_flat[evt_slot] && !(fill_vld && fill_slot == evt_slot) |=>
            !valid_flat[$past(evt_slot)]);

    p_clear_all_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> valid_flat == '0 && cnt_flat == '0);

endmodule

bind pfx_outcome_tracker pfx_outcome_tracker_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .fill_vld   (fill_vld),
    .fill_slot  (fill_slot),
    .evt_vld    (evt_vld),
    .evt_slot   (evt_slot),
    .evict_vld  (evict_vld),
    .evict_slot (evict_slot),
    .valid_flat (valid_flat),
    .cat_flat   (cat_flat),
    .cnt_flat   (cnt_flat)
);

// File: tb/pfx_outcome_tracker_tb.sv
`timescale 1ns/1ps
module pfx_outcome_tracker_tb;
    localparam int SLOTS  = 4;
    localparam int CNT_W  = 8;
    localparam int SW     = 2;
    localparam int MAXC   = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic fill_vld = 1'b0;
    logic [SW-1:0] fill_slot = '0;
    logic evt_vld = 1'b0;
    logic [1:0] evt_kind = '0;
    logic [SW-1:0] evt_slot = '0;
    logic evict_vld = 1'b0;
    logic [SW-1:0] evict_slot = '0;
    logic [2:0] rd_cat = '0;
    logic [CNT_W-1:0] rd_count;

    int checks = 0;
    int failures = 0;

    // Reference model
    bit m_valid [SLOTS];
    int m_cat   [SLOTS];
    int m_cnt   [8];

    always #2 clk = ~clk;

    pfx_outcome_tracker #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .fill_vld(fill_vld), .fill_slot(fill_slot),
        .evt_vld(evt_vld), .evt_kind(evt_kind), .evt_slot(evt_slot),
        .evict_vld(evict_vld), .evict_slot(evict_slot),
        .rd_cat(rd_cat), .rd_count(rd_count)
    );

    function automatic int next_cat(int c, int k);
        case (k)
            0: begin if (c == 0) return 1; if (c == 4) return 5; end
            1: begin if (c == 0) return 4; if (c == 1) return 5;
                     if (c == 2) return 6; if (c == 3) return 7; end
            2: begin if (c == 0) return 2; if (c == 4) return 6; end
            3: begin if (c == 0) return 3; if (c == 4) return 7; end
            default: ;
        endcase
        return c;
    endfunction

    task automatic bump(int c);
        if (m_cnt[c] < MAXC) m_cnt[c]++;
    endtask

    // Called at a negedge; applies one cycle of stimulus and updates the model.
    task automatic step(bit f, int fs, bit e, int ek, int es, bit v, int vs, bit c = 0);
        fill_vld = f; fill_slot = SW'(fs);
        evt_vld = e; evt_kind = 2'(ek); evt_slot = SW'(es);
        evict_vld = v; evict_slot = SW'(vs);
        clr = c;
        @(posedge clk);
        if (c) begin
            for (int i = 0; i < SLOTS; i++) m_valid[i] = 0;
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        end else begin
            if (e && m_valid[es]) m_cat[es] = next_cat(m_cat[es], ek);
            if (v && m_valid[vs]) begin bump(m_cat[vs]); m_valid[vs] = 0; end
            if (f) begin
                if (m_valid[fs]) bump(m_cat[fs]);
                m_valid[fs] = 1; m_cat[fs] = 0;
            end
        end
        @(negedge clk);
        fill_vld = 0; evt_vld = 0; evict_vld = 0; clr = 0;
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < 8; c++) begin
            rd_cat = 3'(c);
            #0.5;
            checks++;
            if (int'(rd_count) != m_cnt[c]) begin
                failures++;
                $display("FAIL %s cat=%0d actual=%0d expected=%0d", tag, c, rd_count, m_cnt[c]);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin m_valid[i] = 0; m_cat[i] = 0; end
        for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R13 reset");

        // Sweep: every event sequence of length 1..3 from a fresh fill
        for (int len = 1; len <= 3; len++) begin
            for (int code = 0; code < (1 << (2 * len)); code++) begin
                int s;
                s = code % SLOTS;
                step(1, s, 0, 0, 0, 0, 0);
                for (int j = 0; j < len; j++)
                    step(0, 0, 1, (code >> (2 * j)) & 3, s, 0, 0);
                step(0, 0, 0, 0, 0, 1, s);
                check_all("R1 R2 R3 R4 R5 R6 R7 sweep");
            end
        end

        // R7: second eviction of the now-invalid slot counts nothing
        step(0, 0, 0, 0, 0, 1, 0);
        check_all("R7 evict invalid");

        // R8: event on invalid slot ignored; later fill still Useless
        step(0, 0, 1, 0, 2, 0, 0);
        step(0, 0, 1, 1, 2, 0, 0);
        step(1, 2, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 2);
        check_all("R8 ignore invalid");

        // R9: event and eviction on the same slot in one cycle
        step(1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 1, 1, 1);
        check_all("R9 event then evict");
        step(1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 1, 0, 0);
        step(0, 0, 1, 3, 1, 1, 1);
        check_all("R9 conflict remote");

        // R10: refill of a live slot counts the old occupant
        step(1, 3, 0, 0, 0, 0, 0);
        step(0, 0, 1, 3, 3, 0, 0);
        step(1, 3, 0, 0, 0, 0, 0);
        check_all("R10 refill");
        step(0, 0, 1, 0, 3, 0, 0);
        step(1, 3, 1, 2, 3, 1, 0);
        check_all("R10 refill with event");
        step(0, 0, 0, 0, 0, 1, 3);
        check_all("R10 final evict");

        // R11: saturation of the Useless counter
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        check_all("R11 saturate");

        // R12: clear drops counters and live slots
        step(1, 2, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        check_all("R12 clear");
        step(0, 0, 0, 0, 0, 1, 2);
        check_all("R12 stale slot");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule